// File: doc/BRIEF.md
# Block-Based Value Prediction Lane Allocator

This block sits between a value predictor that is read once per fetch block and the decode stage. A single entry, read with the block's address, carries a fixed number of value predictions, each paired with its own confidence counter. The block holds that entry until decode reports the micro-ops the block produced. It then hands the predictions out by position: the first micro-op that writes a register takes prediction 0, the second takes prediction 1, and so on. Variable-length instructions that crack into several micro-ops are handled naturally, because only the order of register-writing micro-ops matters.

Decode supplies a micro-op count and a mask of which micro-op slots write a destination register. Allocation is a single-cycle prefix count over that mask, and the result is registered. A prediction is offered only if its confidence counter is saturated. An unconfident prediction still uses up its position. A flush drops any entry that is waiting, so that no stale value reaches a micro-op after a squash.

Top module: `vpred_lane_alloc`

## Requirements
- R1: After reset, `out_fire` is 0 and every bit of `out_vld` is 0.
- R2: The k-th register-writing micro-op of a block (counting from 0 in slot order) receives prediction k. Its `out_val` lane equals bits [k*VAL_W +: VAL_W] of the captured entry, and its `out_idx` lane equals k.
- R3: A prediction is marked valid only when its confidence field (bits [k*CONF_W +: CONF_W] of `ent_conf`) is all ones. An unconfident prediction still consumes position k, so the next register-writing micro-op receives prediction k+1.
- R4: Micro-ops whose `dec_dst` bit is 0 get no prediction and consume no position.
- R5: Register-writing micro-ops beyond the NPRED-th receive no prediction.
- R6: Slots at index `dec_cnt` or above receive no prediction, whatever their `dec_dst` bit says. When `out_fire` is 0, `out_vld` is all zero.
- R7: Results are registered. `out_fire`, `out_vld`, `out_val` and `out_idx` are updated at the clock edge that samples `dec_valid` high while an entry is pending. They return to 0 at the next edge unless another block is allocated.
- R8: A decode with no pending entry produces no result. Each captured entry serves exactly one decode.
- R9: `flush` discards the pending entry and clears the outputs at the next edge. A decode that follows the flush produces nothing.
- R10: A new entry (`ent_valid`) that arrives while another is pending replaces the pending one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Squash: drop the pending entry and clear the outputs |
| ent_valid | input | 1 | A predictor entry is presented this cycle |
| ent_pred | input | NPRED*VAL_W | Predicted values, lane k at [k*VAL_W +: VAL_W] |
| ent_conf | input | NPRED*CONF_W | Confidence counters, lane k at [k*CONF_W +: CONF_W] |
| dec_valid | input | 1 | Decode information for the pending block is present |
| dec_cnt | input | CNT_W | Number of micro-ops the block produced |
| dec_dst | input | MAX_UOPS | Bit i is set when micro-op i writes a register |
| out_fire | output | 1 | An allocation result is presented |
| out_vld | output | MAX_UOPS | Bit i is set when micro-op i has a usable prediction |
| out_val | output | MAX_UOPS*VAL_W | Predicted value for micro-op i |
| out_idx | output | MAX_UOPS*SLOT_W | Prediction lane given to micro-op i |

## Verification
An entry is captured at the edge that samples `ent_valid`. The allocation for a decode appears one edge after `dec_valid` is sampled, and it holds for exactly that one cycle. The bench drives every input on the falling edge and reads the outputs on the following falling edge, half a cycle after the register updates. One falling edge later it checks that `out_fire` has dropped. For flush and for a decode with no entry, the bench samples the same cycle in which a result would otherwise have appeared, so the absence of a result is observed exactly where a wrong design would show it.

// File: rtl/vpa_pkg.sv
package vpa_pkg;
   // width of an index over n items, at least one bit
   function automatic int safe_clog2(input int n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/vpa_entry_buf.sv
// Holds one predictor entry until decode consumes it.
module vpa_entry_buf #(
   parameter int NPRED  = 6,
   parameter int VAL_W  = 64,
   parameter int CONF_W = 3
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    flush,
   input  logic                    load,
   input  logic                    consume,
   input  logic [NPRED*VAL_W-1:0]  in_pred,
   input  logic [NPRED*CONF_W-1:0] in_conf,
   output logic                    pend,
   output logic [NPRED*VAL_W-1:0]  pred_q,
   output logic [NPRED*CONF_W-1:0] conf_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend <= 1'b0;
      end else if (flush) begin
         pend <= 1'b0;
      end else if (load) begin
         pend <= 1'b1;
      end else if (consume) begin
         pend <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pred_q <= '0;
         conf_q <= '0;
      end else if (load && !flush) begin
         pred_q <= in_pred;
         conf_q <= in_conf;
      end
   end
endmodule

// File: rtl/vpa_rank.sv
// Marks register-writing micro-ops inside the count and gives each
// its position among them (exclusive prefix count).
module vpa_rank #(
   parameter int MAX_UOPS = 8,
   parameter int CNT_W    = 4,
   parameter int RANK_W   = 4
) (
   input  logic [CNT_W-1:0]           cnt,
   input  logic [MAX_UOPS-1:0]        dst,
   output logic [MAX_UOPS-1:0]        prod,
   output logic [MAX_UOPS*RANK_W-1:0] rank
);
   for (genvar i = 0; i < MAX_UOPS; i++) begin : g_prod
      assign prod[i] = dst[i] && (CNT_W'(i) < cnt);
   end

   always_comb begin
      logic [RANK_W-1:0] acc;
      acc  = '0;
      rank = '0;
      for (int i = 0; i < MAX_UOPS; i++) begin
         rank[i*RANK_W +: RANK_W] = acc;
         acc = acc + RANK_W'(prod[i]);
      end
   end
endmodule

// File: rtl/vpa_lane_pick.sv
// Selects the prediction for one micro-op lane from its rank.
module vpa_lane_pick #(
   parameter int NPRED  = 6,
   parameter int VAL_W  = 64,
   parameter int CONF_W = 3,
   parameter int RANK_W = 4,
   parameter int SLOT_W = 3
) (
   input  logic                    prod,
   input  logic [RANK_W-1:0]       rank,
   input  logic [NPRED*VAL_W-1:0]  pred,
   input  logic [NPRED*CONF_W-1:0] conf,
   output logic                    vld,
   output logic [VAL_W-1:0]        val,
   output logic [SLOT_W-1:0]       idx
);
   always_comb begin
      logic hit;
      logic sat;
      hit = 1'b0;
      sat = 1'b0;
      val = '0;
      idx = '0;
      for (int k = 0; k < NPRED; k++) begin
         if (rank == RANK_W'(k)) begin
            hit = prod;
            sat = &conf[k*CONF_W +: CONF_W];
            val = pred[k*VAL_W +: VAL_W];
            idx = SLOT_W'(k);
         end
      end
      vld = hit && sat;
      if (!vld) begin
         val = '0;
         idx = '0;
      end
   end
endmodule

// File: rtl/vpred_lane_alloc.sv
module vpred_lane_alloc #(
   parameter  int NPRED    = 6,
   parameter  int VAL_W    = 64,
   parameter  int CONF_W   = 3,
   parameter  int MAX_UOPS = 8,
   localparam int CNT_W    = $clog2(MAX_UOPS + 1),
   localparam int SLOT_W   = vpa_pkg::safe_clog2(NPRED)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       flush,
   input  logic                       ent_valid,
   input  logic [NPRED*VAL_W-1:0]     ent_pred,
   input  logic [NPRED*CONF_W-1:0]    ent_conf,
   input  logic                       dec_valid,
   input  logic [CNT_W-1:0]           dec_cnt,
   input  logic [MAX_UOPS-1:0]        dec_dst,
   output logic                       out_fire,
   output logic [MAX_UOPS-1:0]        out_vld,
   output logic [MAX_UOPS*VAL_W-1:0]  out_val,
   output logic [MAX_UOPS*SLOT_W-1:0] out_idx
);
   localparam int RANK_W = $clog2(vpa_pkg::max2(NPRED, MAX_UOPS) + 1);

   if (NPRED < 2 || NPRED > 16) begin : g_bad_npred
      $error("NPRED must lie in 2..16");
   end
   if (MAX_UOPS < 1 || MAX_UOPS > 8) begin : g_bad_uops
      $error("MAX_UOPS must lie in 1..8");
   end
   if (CONF_W < 1 || VAL_W < 1) begin : g_bad_width
      $error("CONF_W and VAL_W must be positive");
   end

   logic                       pend;
   logic [NPRED*VAL_W-1:0]     pred_q;
   logic [NPRED*CONF_W-1:0]    conf_q;
   logic                       consume;
   logic                       fire_d;
   logic [MAX_UOPS-1:0]        prod;
   logic [MAX_UOPS*RANK_W-1:0] rank;
   logic [MAX_UOPS-1:0]        lane_vld;
   logic [MAX_UOPS*VAL_W-1:0]  lane_val;
   logic [MAX_UOPS*SLOT_W-1:0] lane_idx;

   assign consume = dec_valid && pend;
   assign fire_d  = consume && !flush;

   vpa_entry_buf #(.NPRED(NPRED), .VAL_W(VAL_W), .CONF_W(CONF_W)) u_buf (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .load(ent_valid), .consume(consume),
      .in_pred(ent_pred), .in_conf(ent_conf),
      .pend(pend), .pred_q(pred_q), .conf_q(conf_q)
   );

   vpa_rank #(.MAX_UOPS(MAX_UOPS), .CNT_W(CNT_W), .RANK_W(RANK_W)) u_rank (
      .cnt(dec_cnt), .dst(dec_dst), .prod(prod), .rank(rank)
   );

   for (genvar i = 0; i < MAX_UOPS; i++) begin : g_lane
      vpa_lane_pick #(
         .NPRED(NPRED), .VAL_W(VAL_W), .CONF_W(CONF_W),
         .RANK_W(RANK_W), .SLOT_W(SLOT_W)
      ) u_pick (
         .prod(prod[i]),
         .rank(rank[i*RANK_W +: RANK_W]),
         .pred(pred_q),
         .conf(conf_q),
         .vld(lane_vld[i]),
         .val(lane_val[i*VAL_W +: VAL_W]),
         .idx(lane_idx[i*SLOT_W +: SLOT_W])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         out_fire <= 1'b0;
         out_vld  <= '0;
         out_val  <= '0;
         out_idx  <= '0;
      end else begin
         out_fire <= fire_d;
         out_vld  <= fire_d ? lane_vld : '0;
         out_val  <= fire_d ? lane_val : '0;
         out_idx  <= fire_d ? lane_idx : '0;
      end
   end
endmodule

// File: rtl/vpa_checker.sv
module vpa_checker #(
   parameter int NPRED    = 6,
   parameter int VAL_W    = 64,
   parameter int CONF_W   = 3,
   parameter int MAX_UOPS = 8,
   parameter int CNT_W    = 4,
   parameter int SLOT_W   = 3
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       flush,
   input logic                       dec_valid,
   input logic [CNT_W-1:0]           dec_cnt,
   input logic [MAX_UOPS-1:0]        dec_dst,
   input logic                       out_fire,
   input logic [MAX_UOPS-1:0]        out_vld,
   input logic [MAX_UOPS*SLOT_W-1:0] out_idx
);
   // R8: a result follows a decode that was not flushed
   a_r8_fire_from_decode: assert property (@(posedge clk) disable iff (!rst_n)
      out_fire |-> ($past(dec_valid) && !$past(flush)));

   // R9: a flush leaves the outputs empty on the next cycle
   a_r9_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (!out_fire && out_vld == '0));

   // R6: no valid lane without a result
   a_r6_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !out_fire |-> out_vld == '0);

   // R5: never more usable lanes than predictions
   a_r5_cap: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(out_vld) <= NPRED);

   // R4: only register-writing micro-ops get predictions
   a_r4_dst_only: assert property (@(posedge clk) disable iff (!rst_n)
      out_fire |-> (out_vld & ~$past(dec_dst)) == '0);

   for (genvar i = 0; i < MAX_UOPS; i++) begin : g_lane
      // R6: lanes at or past the count stay empty
      a_r6_within_count: assert property (@(posedge clk) disable iff (!rst_n)
         out_vld[i] |-> (CNT_W'(i) < $past(dec_cnt)));
      for (genvar j = i + 1; j < MAX_UOPS; j++) begin : g_pair
         // R2: prediction lanes rise with slot order
         a_r2_in_order: assert property (@(posedge clk) disable iff (!rst_n)
            (out_vld[i] && out_vld[j]) |->
               (out_idx[i*SLOT_W +: SLOT_W] < out_idx[j*SLOT_W +: SLOT_W]));
      end
   end
endmodule

bind vpred_lane_alloc vpa_checker #(
   .NPRED(NPRED), .VAL_W(VAL_W), .CONF_W(CONF_W),
   .MAX_UOPS(MAX_UOPS), .CNT_W(CNT_W), .SLOT_W(SLOT_W)
) u_vpa_checker (
   .clk(clk), .rst_n(rst_n), .flush(flush), .dec_valid(dec_valid),
   .dec_cnt(dec_cnt), .dec_dst(dec_dst), .out_fire(out_fire),
   .out_vld(out_vld), .out_idx(out_idx)
);

// File: tb/tb_vpred_lane_alloc.sv
module tb_vpred_lane_alloc;
   localparam int NP = 6;
   localparam int VW = 64;
   localparam int CW = 3;
   localparam int NU = 8;
   localparam int SW = 3;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            flush = 1'b0;
   logic            ent_valid = 1'b0;
   logic [NP*VW-1:0] ent_pred = '0;
   logic [NP*CW-1:0] ent_conf = '0;
   logic            dec_valid = 1'b0;
   logic [3:0]      dec_cnt = '0;
   logic [NU-1:0]   dec_dst = '0;
   logic            out_fire;
   logic [NU-1:0]   out_vld;
   logic [NU*VW-1:0] out_val;
   logic [NU*SW-1:0] out_idx;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   vpred_lane_alloc #(.NPRED(NP), .VAL_W(VW), .CONF_W(CW), .MAX_UOPS(NU)) dut (
      .clk(clk), .rst_n(rst_n), .flush(flush), .ent_valid(ent_valid),
      .ent_pred(ent_pred), .ent_conf(ent_conf), .dec_valid(dec_valid),
      .dec_cnt(dec_cnt), .dec_dst(dec_dst), .out_fire(out_fire),
      .out_vld(out_vld), .out_val(out_val), .out_idx(out_idx)
   );

   task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                      input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   function automatic logic [63:0] pv(input logic [63:0] base, input int k);
      return base + 64'(k) * 64'h0101_0101_0000_0011;
   endfunction

   // drives an entry for one cycle; conf_ok bit k selects saturated (7) or 3
   task automatic load_entry(input logic [63:0] base, input logic [NP-1:0] conf_ok);
      @(negedge clk);
      ent_valid = 1'b1;
      for (int k = 0; k < NP; k++) begin
         ent_pred[k*VW +: VW] = pv(base, k);
         ent_conf[k*CW +: CW] = conf_ok[k] ? 3'b111 : 3'b011;
      end
      @(negedge clk);
      ent_valid = 1'b0;
   endtask

   // presents decode info for one cycle; returns at the cycle the result is due
   task automatic decode(input logic [3:0] cnt, input logic [NU-1:0] mask);
      dec_valid = 1'b1;
      dec_cnt   = cnt;
      dec_dst   = mask;
      @(negedge clk);
      dec_valid = 1'b0;
      dec_cnt   = '0;
      dec_dst   = '0;
   endtask

   // compares every lane against the positional rule
   task automatic check_lanes(input string tag, input logic [63:0] base,
                              input logic [NP-1:0] conf_ok, input logic [3:0] cnt,
                              input logic [NU-1:0] mask);
      int r;
      r = 0;
      chk(out_fire == 1'b1, {tag, " R7 fire"}, 64'(out_fire), 64'd1);
      for (int i = 0; i < NU; i++) begin
         bit ev;
         int ek;
         ev = 1'b0;
         ek = 0;
         if (i < int'(cnt) && mask[i]) begin
            if (r < NP) begin
               ev = conf_ok[r];
               ek = r;
            end
            r++;
         end
         chk(out_vld[i] == ev, $sformatf("%s vld lane %0d", tag, i),
             64'(out_vld[i]), 64'(ev));
         if (ev) begin
            chk(out_val[i*VW +: VW] == pv(base, ek), $sformatf("%s R2 val lane %0d", tag, i),
                out_val[i*VW +: VW], pv(base, ek));
            chk(int'(out_idx[i*SW +: SW]) == ek, $sformatf("%s R2 idx lane %0d", tag, i),
                64'(out_idx[i*SW +: SW]), 64'(ek));
         end
      end
      @(negedge clk);
      chk(out_fire == 1'b0 && out_vld == '0, {tag, " R7 one-cycle"}, 64'(out_fire), 64'd0);
   endtask

   task automatic t_reset();
      chk(out_fire == 1'b0, "R1 fire at reset", 64'(out_fire), 64'd0);
      chk(out_vld == '0, "R1 vld at reset", 64'(out_vld), 64'd0);
   endtask

   task automatic t_basic();
      load_entry(64'h1000_0000_0000_0000, 6'b111111);
      decode(4'd6, 8'b0011_1111);
      check_lanes("R2 basic", 64'h1000_0000_0000_0000, 6'b111111, 4'd6, 8'b0011_1111);
   endtask

   task automatic t_lowconf();
      load_entry(64'h2000_0000_0000_0000, 6'b111101);
      decode(4'd4, 8'b0000_1111);
      check_lanes("R3 lowconf", 64'h2000_0000_0000_0000, 6'b111101, 4'd4, 8'b0000_1111);
   endtask

   task automatic t_skip();
      load_entry(64'h3000_0000_0000_0000, 6'b111111);
      decode(4'd8, 8'b1011_0100);
      check_lanes("R4 skip", 64'h3000_0000_0000_0000, 6'b111111, 4'd8, 8'b1011_0100);
   endtask

   task automatic t_overflow();
      load_entry(64'h4000_0000_0000_0000, 6'b111111);
      decode(4'd8, 8'b1111_1111);
      check_lanes("R5 overflow", 64'h4000_0000_0000_0000, 6'b111111, 4'd8, 8'b1111_1111);
   endtask

   task automatic t_count();
      load_entry(64'h5000_0000_0000_0000, 6'b111111);
      decode(4'd3, 8'b1111_1111);
      check_lanes("R6 count", 64'h5000_0000_0000_0000, 6'b111111, 4'd3, 8'b1111_1111);
   endtask

   task automatic t_nopend();
      @(negedge clk);
      decode(4'd8, 8'b1111_1111);
      chk(out_fire == 1'b0 && out_vld == '0, "R8 decode without entry", 64'(out_vld), 64'd0);
      load_entry(64'h6000_0000_0000_0000, 6'b111111);
      decode(4'd2, 8'b0000_0011);
      check_lanes("R8 single", 64'h6000_0000_0000_0000, 6'b111111, 4'd2, 8'b0000_0011);
      decode(4'd2, 8'b0000_0011);
      chk(out_fire == 1'b0 && out_vld == '0, "R8 entry reused", 64'(out_vld), 64'd0);
   endtask

   task automatic t_flush();
      load_entry(64'h7000_0000_0000_0000, 6'b111111);
      flush = 1'b1;
      @(negedge clk);
      flush = 1'b0;
      decode(4'd4, 8'b0000_1111);
      chk(out_fire == 1'b0 && out_vld == '0, "R9 flushed entry used", 64'(out_vld), 64'd0);
      // flush in the same cycle as decode
      load_entry(64'h7100_0000_0000_0000, 6'b111111);
      flush = 1'b1;
      decode(4'd4, 8'b0000_1111);
      flush = 1'b0;
      chk(out_fire == 1'b0 && out_vld == '0, "R9 flush with decode", 64'(out_vld), 64'd0);
   endtask

   task automatic t_replace();
      load_entry(64'h8000_0000_0000_0000, 6'b111111);
      load_entry(64'h9000_0000_0000_0000, 6'b011111);
      decode(4'd7, 8'b0111_1111);
      check_lanes("R10 replace", 64'h9000_0000_0000_0000, 6'b011111, 4'd7, 8'b0111_1111);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_basic();
      t_lowconf();
      t_skip();
      t_overflow();
      t_count();
      t_nopend();
      t_flush();
      t_replace();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog act=running exp=finished");
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end
endmodule